// File: doc/BRIEF.md
# Periodic Tick Counter

This block turns a fast system clock into a slow, evenly spaced stream of events without ever using a divided signal as a clock. A free-running binary timer advances on every system clock edge. The timer's top bit is also held in a one-bit register that records its value from the previous cycle. A one-cycle tick is raised whenever that stored bit is 0 and the live top bit is 1.

Each tick advances a small modulo counter that steps 0, 1, 2, 3, 4, 5 and then returns to 0. Its value is the block's main output. The tick is also brought out so that other logic can use it as a clock enable.

The timer width and the counter's wrap value are parameters. The tick is always taken from the timer's top bit, so changing the width needs no other edit. Everything runs in one clock domain, under a synchronous active-low reset.

Top module: `periodic_tick_counter`

## Requirements
- R1: The internal timer, `TMR_W` bits wide (default 26), increases by one on every clock edge outside reset and wraps from all ones to zero. At the ports this shows as the tick timing in R2 and R6.
- R2: `tick` is 1 exactly in those cycles where the stored previous top bit of the timer is 0 and the current top bit is 1. After reset is released, the first tick arrives 2^(TMR_W-1) cycles after the first active clock edge.
- R3: `tick` is never high for two consecutive cycles.
- R4: `count` is `$clog2(WRAP+1)` bits wide (3 bits for the default `WRAP` = 5). It takes the values 0, 1, …, WRAP in order, and a tick while `count` equals WRAP returns it to 0.
- R5: `count` holds its value in every cycle in which `tick` is 0.
- R6: Outside reset, consecutive ticks are spaced exactly 2^TMR_W clock cycles apart.
- R7: `rst_n` low at a clock edge clears the timer, the stored top bit and `count` to 0. This applies even when a tick is present in that same cycle, and the tick then has no effect. `tick` is 0 while reset is held and in the first cycle after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register in the block uses it |
| rst_n | input | 1 | Synchronous reset, active low |
| count | output | $clog2(WRAP+1) (3) | Modulo state counter value |
| tick | output | 1 | One-cycle pulse on the rise of the timer's top bit |

## Verification
Two functions can land in the same cycle. A counter step, including the step that wraps from WRAP back to 0, can coincide with a reset edge, and a tick can arrive in the very cycle that reset is asserted. The bench provokes this directly: it runs until its own model predicts a tick, holds `rst_n` low for the edge that closes that cycle, and expects `count` to read 0 rather than the stepped value. It also expects the next tick to fall 2^(TMR_W-1) cycles after release. Random reset pulses of random length, placed at random points in the tick period, repeat this mix against the same cycle-exact model.

// File: rtl/tick_pkg.sv
// Package: shared helpers for the periodic tick counter.
// Assumes: callers pass a non-negative wrap value.
package tick_pkg;

    // Width needed to hold values 0..wrap (at least one bit).
    function automatic int count_width(input int wrap);
        int w;
        w = 1;
        while ((1 << w) <= wrap) w++;
        return w;
    endfunction

endpackage

// File: rtl/free_timer.sv
// Module: free_timer
// Free-running binary timer that advances every clock and wraps naturally.
// Only its top bit leaves the module; the width is the sole parameter.
// Assumes: synchronous active-low reset, W >= 2.
module free_timer #(
    parameter int W = 26
) (
    input  logic clk,
    input  logic rst_n,
    output logic msb
);
    localparam int TOP = W - 1;

    logic [W-1:0] tmr_q;

    // Advance the timer by one each cycle; reset returns it to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_q + 1'b1;
    end

    assign msb = tmr_q[TOP];

    // R1: the timer steps by exactly one between two edges outside reset
    p_timer_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> tmr_q == $past(tmr_q) + 1'b1);

    // R7: the edge after reset leaves the timer at zero
    p_timer_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> tmr_q == '0);
endmodule

// File: rtl/rise_detect.sv
// Module: rise_detect
// Stores a level from the previous cycle and raises a one-cycle pulse on
// a 0-to-1 change. The pulse is combinational from the live level and the
// stored copy, so it is valid in the cycle where the level first reads 1.
// Assumes: level is produced by a register in the same clock domain.
module rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse
);
    logic prev_q;

    // Keep last cycle's level; reset stores zero.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    // Pulse when the level is high now and was low before.
    always_comb pulse = level & ~prev_q;

    // R3: a pulse never lasts two cycles
    p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    // R2: a pulse is always followed by a stored high level
    p_prev_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> prev_q);
endmodule

// File: rtl/mod_counter.sv
// Module: mod_counter
// Counts 0..WRAP on each enable and returns to 0 after WRAP; holds otherwise.
// When WRAP+1 is a power of two the natural binary rollover is used.
// Assumes: CNT_W can hold WRAP; synchronous active-low reset.
module mod_counter #(
    parameter int WRAP  = 5,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] WRAP_V = CNT_W'(WRAP);
    localparam bit POW2 = ((WRAP + 1) == (1 << CNT_W));

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;

    generate
        if (POW2) begin : g_natural
            // Full binary range: plain increment wraps by itself.
            always_comb cnt_next = cnt_q + 1'b1;
        end else begin : g_compare
            // Partial range: compare with the wrap value.
            always_comb cnt_next = (cnt_q == WRAP_V) ? '0 : cnt_q + 1'b1;
        end
    endgenerate

    // Step only on enable; reset clears.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (step) cnt_q <= cnt_next;
    end

    assign count = cnt_q;

    // R5: no enable, no change
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q));

    // R4: an enable at the top value returns to zero
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q == WRAP_V) |=> cnt_q == '0);

    // R4: the value never leaves 0..WRAP
    p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= WRAP_V);
endmodule

// File: rtl/periodic_tick_counter.sv
// Module: periodic_tick_counter (top)
// Timer -> top-bit rise detector -> modulo counter, all on one clock.
// No timer bit is used as a clock; the tick is a clock enable only.
// Assumes: TMR_W >= 2, WRAP >= 1, synchronous active-low reset.
module periodic_tick_counter #(
    parameter int TMR_W = 26,
    parameter int WRAP  = 5,
    localparam int CNT_W = tick_pkg::count_width(WRAP)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count,
    output logic             tick
);
    logic tmr_msb;

    free_timer #(.W(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .msb   (tmr_msb)
    );

    rise_detect u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (tmr_msb),
        .pulse (tick)
    );

    mod_counter #(.WRAP(WRAP), .CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (tick),
        .count (count)
    );

    // R7: no tick in the first cycle after reset release
    p_no_tick_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !tick);

    // R7: the first cycle after reset shows a zero count
    p_count_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> count == '0);
endmodule

// File: tb/periodic_tick_counter_bench.sv
// Bench: cycle-exact model of the requirements, random reset pulses with a
// fixed seed, and directed reset-on-tick corner cases.
module periodic_tick_counter_bench;
    localparam int TMR_W  = 6;
    localparam int WRAP   = 5;
    localparam int PERIOD = 1 << TMR_W;
    localparam int HALF   = 1 << (TMR_W - 1);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] count;
    logic       tick;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Model state (values held by the registers after the last edge).
    logic [TMR_W-1:0] m_tmr = '0;
    logic             m_prev = 1'b0;
    logic [2:0]       m_cnt = '0;
    int since_tick = -1;
    int since_rel = -1;
    logic last_tick = 1'b0;

    periodic_tick_counter #(.TMR_W(TMR_W), .WRAP(WRAP)) u_periodic_tick_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .count (count),
        .tick  (tick)
    );

    always #10 clk = ~clk; // 50 MHz

    function automatic logic exp_tick(input logic [TMR_W-1:0] t, input logic p);
        return t[TMR_W-1] & ~p;
    endfunction

    function automatic logic [2:0] exp_next(input logic [2:0] c);
        return (c == 3'(WRAP)) ? 3'd0 : c + 3'd1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // One cycle: check outputs at the negedge, then drive rst_n for the
    // next edge and advance the model to match.
    task automatic step(input logic r);
        logic et;
        @(negedge clk);
        et = exp_tick(m_tmr, m_prev) & rst_n;
        check("R2 tick", int'(tick), int'(et));
        check("R4/R5 count", int'(count), int'(m_cnt));
        if (tick && last_tick) check("R3 tick width", 2, 1);
        if (tick && rst_n) begin
            if (since_tick >= 0) check("R6 tick spacing", since_tick, PERIOD);
            else if (since_rel >= 0) check("R2 first tick after release", since_rel, HALF);
        end
        last_tick = tick;
        rst_n = r;
        if (!r) begin
            m_tmr = '0; m_prev = 1'b0; m_cnt = '0;
            since_tick = -1; since_rel = -1;
        end else begin
            if (et) begin m_cnt = exp_next(m_cnt); since_tick = 1; end
            else if (since_tick >= 0) since_tick++;
            since_rel = (since_rel < 0) ? 1 : since_rel + 1;
            m_prev = m_tmr[TMR_W-1];
            m_tmr = m_tmr + 1'b1;
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5eed_0071);
        // Reset state (R7).
        repeat (3) step(1'b0);
        check("R7 reset count", int'(count), 0);
        check("R7 reset tick", int'(tick), 0);
        // Long free run covering several wraps (R1, R2, R4, R5, R6).
        repeat (PERIOD * (WRAP + 3)) step(1'b1);
        // Directed: reset in the very cycle of a tick, twice (R7).
        for (int k = 0; k < 2; k++) begin
            while (!(exp_tick(m_tmr, m_prev) && rst_n)) step(1'b1);
            step(1'b0);
            step(1'b1);
            check("R7 count cleared on tick-cycle reset", int'(count), 0);
            repeat (PERIOD * 2) step(1'b1);
        end
        // Directed: reset while the count sits at WRAP and a tick arrives.
        while (!(m_cnt == 3'(WRAP) && exp_tick(m_tmr, m_prev))) step(1'b1);
        step(1'b0);
        step(1'b1);
        check("R7 wrap tick overridden by reset", int'(count), 0);
        // Random reset pulses at random points in the period.
        for (int i = 0; i < 30; i++) begin
            int run;
            int hold;
            run = 1 + int'($urandom % (PERIOD * 3));
            hold = 1 + int'($urandom % 4);
            repeat (run) step(1'b1);
            repeat (hold) step(1'b0);
        end
        repeat (PERIOD * (WRAP + 2)) step(1'b1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule